// File: doc/BRIEF.md
# DAC Readback Frame Sequencer

This block builds a frame that reports the locally held DAC settings into the transmit buffer of an external network controller, then tells the controller to send it. A one-cycle start event is taken from the rising edge of a state-enable condition, which holds while the incoming 3-bit state code equals a trigger value. From that event the block runs a fixed sequence of single-byte writes. First it writes an ASCII tag byte. It then writes every DAC channel in ascending order, two bytes per channel. Where the frame would be shorter than the minimum payload, it appends zero bytes. Last, it writes a send command.

Each write uses a go/done handshake. The block raises a go strobe together with the read/write flag, an address and a data byte, and it waits for the controller's done before it starts the next access. The block drives a channel index so that the register file can present the selected 14-bit value on the data input during the access. When the controller acknowledges the send command, the block emits a one-cycle write of the next state code to the state register.

Top module: `dac_frame_seq`

## Requirements
- R1: While reset (asynchronous, active low) is asserted, txGo and stateWr are 0 and newState is 3'b000.
- R2: A frame starts only on a rising edge of (stateCode == TRIG_STATE). Holding the trigger code does not restart the block, another code does not start it, and an edge that arrives while a frame is in progress is ignored.
- R3: The first access of a frame writes 8'h44 (ASCII "D") to address 0.
- R4: For channel k, counted from 0 upward, buffer address 1+2k receives {2'b00, value[13:8]} and address 2+2k receives value[7:0]. chSel equals k during both of these accesses.
- R5: When 1+2*NUM_CH is below MIN_BYTES, the addresses from 1+2*NUM_CH up to MIN_BYTES-1 each receive 8'h00.
- R6: txGo is high for exactly one cycle per access. After a txGo, no further txGo is issued until txDone has been seen, and a txDone that arrives in the same cycle as txGo or while idle is ignored.
- R7: Every access is a write, shown by txRw = 0 whenever txGo is high.
- R8: After the last buffer byte, one access writes the frame length, max(1+2*NUM_CH, MIN_BYTES), to address SEND_ADDR (8'hFF).
- R9: The cycle after the send command's txDone, stateWr is high for one cycle with newState = 3'b010. At every other time newState is 3'b000.
- R10: txAddr holds its value from the txGo of an access until that access's txDone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stateCode | input | 3 | Current state code; the trigger value enables a frame |
| chSel | output | CH_W | Channel index presented to the DAC register file |
| dacData | input | DATA_W | Value of the selected channel |
| txGo | output | 1 | One-cycle access strobe to the controller |
| txRw | output | 1 | Access direction, 0 = write |
| txAddr | output | ADDR_W | Buffer address, or SEND_ADDR for the send command |
| txData | output | 8 | Byte to write |
| txDone | input | 1 | Controller has finished the current access |
| newState | output | 3 | Next state code, 3'b010 while stateWr is high |
| stateWr | output | 1 | One-cycle write strobe to the state register |

## Verification
The bench builds the block three times, with NUM_CH set to 32, 24 and 16, and drives all three from the same trigger code. The 32- and 24-channel builds produce 65- and 49-byte frames with no fill. The 16-channel build yields 33 data bytes and so reaches the zero-fill path up to 46 bytes and a different send length. Controller latency is random, and spurious done pulses are injected in the go cycle. The frames use all-ones, all-zero and random channel values.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SEND,
    ST_SEND_WAIT,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic selSend;
  } dpCtrl_t;

  localparam logic [7:0] TAG_BYTE  = 8'h44;
  localparam logic [2:0] NEXT_CODE = 3'b010;

endpackage

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dac_frame_pkg::*;
#(
  parameter logic [2:0] TRIG_STATE = 3'b111
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] stateCode,
  input  logic       txDone,
  input  logic       lastByte,
  output dpCtrl_t    dpCtrl,
  output logic       txGo,
  output logic       txRw,
  output logic       stateWr,
  output logic [2:0] newState
);

  seqState_t state, nxtState;
  logic      enNow, enQ, startPulse;

  assign enNow      = (stateCode == TRIG_STATE);
  assign startPulse = enNow & ~enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      enQ   <= 1'b0;
    end else begin
      state <= nxtState;
      enQ   <= enNow;
    end
  end

  always_comb begin
    nxtState = state;
    dpCtrl   = '0;
    txGo     = 1'b0;
    stateWr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          dpCtrl.clrIdx = 1'b1;
          nxtState      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        txGo     = 1'b1;
        nxtState = ST_WAIT;
      end
      ST_WAIT: begin
        if (txDone) begin
          if (lastByte) begin
            nxtState = ST_SEND;
          end else begin
            dpCtrl.incIdx = 1'b1;
            nxtState      = ST_ISSUE;
          end
        end
      end
      ST_SEND: begin
        dpCtrl.selSend = 1'b1;
        txGo           = 1'b1;
        nxtState       = ST_SEND_WAIT;
      end
      ST_SEND_WAIT: begin
        dpCtrl.selSend = 1'b1;
        if (txDone) nxtState = ST_FINISH;
      end
      ST_FINISH: begin
        stateWr  = 1'b1;
        nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  // every access of this sequencer is a write
  assign txRw     = 1'b0;
  assign newState = stateWr ? NEXT_CODE : 3'b000;

endmodule

// File: rtl/dac_frame_dp.sv
module dac_frame_dp
  import dac_frame_pkg::*;
#(
  parameter int         NUM_CH      = 32,
  parameter int         DATA_W      = 14,
  parameter int         ADDR_W      = 8,
  parameter int         RAW_BYTES   = 65,
  parameter int         FRAME_BYTES = 65,
  parameter int         IDX_W       = 7,
  parameter int         CH_W        = 5,
  parameter logic [7:0] SEND_ADDR   = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] dacData,
  output logic              lastByte,
  output logic [CH_W-1:0]   chSel,
  output logic [ADDR_W-1:0] txAddr,
  output logic [7:0]        txData
);

  logic [IDX_W-1:0] byteIdx, chOff;
  logic             inChan;
  logic [15:0]      wideVal;
  logic [7:0]       chanByte, bodyByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              byteIdx <= '0;
    else if (dpCtrl.clrIdx) byteIdx <= '0;
    else if (dpCtrl.incIdx) byteIdx <= byteIdx + 1'b1;
  end

  assign lastByte = (byteIdx == IDX_W'(FRAME_BYTES - 1));
  assign chOff    = byteIdx - IDX_W'(1);
  assign inChan   = (byteIdx != '0) && (byteIdx <= IDX_W'(2 * NUM_CH));
  assign chSel    = inChan ? chOff[CH_W:1] : '0;

  // zero-extend, high byte first (even offset within a channel)
  assign wideVal  = 16'(dacData);
  assign chanByte = chOff[0] ? wideVal[7:0] : wideVal[15:8];

  generate
    if (FRAME_BYTES > RAW_BYTES) begin : gen_fill
      assign bodyByte = (byteIdx == '0) ? TAG_BYTE :
                        inChan          ? chanByte : 8'h00;
    end else begin : gen_nofill
      assign bodyByte = (byteIdx == '0) ? TAG_BYTE : chanByte;
    end
  endgenerate

  assign txData = dpCtrl.selSend ? 8'(FRAME_BYTES) : bodyByte;
  assign txAddr = dpCtrl.selSend ? ADDR_W'(SEND_ADDR) : ADDR_W'(byteIdx);

endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
  import dac_frame_pkg::*;
#(
  parameter int         NUM_CH     = 32,
  parameter int         DATA_W     = 14,
  parameter int         ADDR_W     = 8,
  parameter int         MIN_BYTES  = 46,
  parameter logic [7:0] SEND_ADDR  = 8'hFF,
  parameter logic [2:0] TRIG_STATE = 3'b111,
  localparam int        RAW_BYTES  = 1 + 2 * NUM_CH,
  localparam int        FRAME_BYTES = (RAW_BYTES > MIN_BYTES) ? RAW_BYTES : MIN_BYTES,
  localparam int        IDX_W      = $clog2(FRAME_BYTES + 1),
  localparam int        CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        stateCode,
  output logic [CH_W-1:0]   chSel,
  input  logic [DATA_W-1:0] dacData,
  output logic              txGo,
  output logic              txRw,
  output logic [ADDR_W-1:0] txAddr,
  output logic [7:0]        txData,
  input  logic              txDone,
  output logic [2:0]        newState,
  output logic              stateWr
);

  dpCtrl_t dpCtrl;
  logic    lastByte;

  dac_frame_ctrl #(
    .TRIG_STATE(TRIG_STATE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stateCode(stateCode),
    .txDone   (txDone),
    .lastByte (lastByte),
    .dpCtrl   (dpCtrl),
    .txGo     (txGo),
    .txRw     (txRw),
    .stateWr  (stateWr),
    .newState (newState)
  );

  dac_frame_dp #(
    .NUM_CH     (NUM_CH),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .RAW_BYTES  (RAW_BYTES),
    .FRAME_BYTES(FRAME_BYTES),
    .IDX_W      (IDX_W),
    .CH_W       (CH_W),
    .SEND_ADDR  (SEND_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .dacData (dacData),
    .lastByte(lastByte),
    .chSel   (chSel),
    .txAddr  (txAddr),
    .txData  (txData)
  );

endmodule

// File: rtl/dac_frame_chk.sv
module dac_frame_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txGo,
  input logic              txDone,
  input logic [ADDR_W-1:0] txAddr,
  input logic [2:0]        newState,
  input logic              stateWr
);

  // an access is outstanding from its go until its done
  logic outstanding;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       outstanding <= 1'b0;
    else if (txGo)   outstanding <= 1'b1;
    else if (txDone) outstanding <= 1'b0;
  end

  p_go_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    txGo |=> !txGo);

  p_go_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    txGo |-> !outstanding);

  p_addr_after_go_r10: assert property (@(posedge clk) disable iff (!rstN)
    txGo |=> $stable(txAddr));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && !txDone) |=> $stable(txAddr));

  p_finish_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    stateWr |-> (newState == 3'b010));

  p_quiet_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stateWr |-> (newState == 3'b000));

  p_finish_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    stateWr |=> !stateWr);

  p_finish_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    stateWr |-> (!txGo && !outstanding));

endmodule

bind dac_frame_seq dac_frame_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .txGo    (txGo),
  .txDone  (txDone),
  .txAddr  (txAddr),
  .newState(newState),
  .stateWr (stateWr)
);

// File: tb/dac_frame_seq_agent.sv
module dac_frame_seq_agent #(
  parameter int NCH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] stateCode,
  output int         checks,
  output int         fails,
  output int         frames,
  output int         accIdx
);

  localparam int RAW  = 1 + 2 * NCH;
  localparam int FLEN = (RAW > 46) ? RAW : 46;
  localparam int CW   = $clog2(NCH);

  logic [CW-1:0] chSel;
  logic [13:0]   dacData;
  logic          txGo, txRw, txDone, stateWr;
  logic [7:0]    txAddr, txData;
  logic [2:0]    newState;
  logic [13:0]   mem [32];

  int   cnt;
  bit   prevGo, rstSeen;
  logic [7:0] goAddr;

  assign dacData = mem[32'(chSel)];

  dac_frame_seq #(.NUM_CH(NCH)) u_dac_frame_seq (
    .clk(clk), .rstN(rstN), .stateCode(stateCode), .chSel(chSel),
    .dacData(dacData), .txGo(txGo), .txRw(txRw), .txAddr(txAddr),
    .txData(txData), .txDone(txDone), .newState(newState), .stateWr(stateWr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (NCH=%0d) actual=%0h expected=%0h", req, NCH, act, exp);
    end
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < 32; i++)
      mem[i] = (mode == 0) ? 14'h3FFF : (mode == 1) ? 14'h0000 : 14'($urandom);
  endtask

  function automatic logic [7:0] expByte(input int idx);
    int ch;
    if (idx == 0) return 8'h44;
    if (idx <= 2 * NCH) begin
      ch = (idx - 1) / 2;
      if (((idx - 1) % 2) == 0) return {2'b00, mem[ch][13:8]};
      return mem[ch][7:0];
    end
    return 8'h00;
  endfunction

  initial begin
    checks = 0; fails = 0; frames = 0; accIdx = 0;
    cnt = 0; prevGo = 0; rstSeen = 0; txDone = 0; goAddr = '0;
    fill(0);
  end

  always @(negedge clk) begin
    bit doneNow;
    if (!rstN) begin
      if (!rstSeen) begin
        chk(txGo == 0 && stateWr == 0, "R1 strobes in reset", {txGo, stateWr}, 0);
        chk(newState == 3'b000, "R1 newState in reset", newState, 0);
        rstSeen = 1;
      end
      accIdx = 0; cnt = 0; txDone = 0; prevGo = 0;
    end else begin
      doneNow = 0;
      if (cnt > 0) begin
        if (txAddr != goAddr) chk(0, "R10 address held", txAddr, goAddr);
        cnt--;
        if (cnt == 0) begin
          doneNow = 1;
          chk(txAddr == goAddr, "R10 address at done", txAddr, goAddr);
        end
      end
      if (txGo) begin
        chk(!prevGo, "R6 single-cycle go", prevGo, 0);
        chk(cnt == 0 && !doneNow, "R6 go before done", cnt, 0);
        chk(txRw == 1'b0, "R7 write flag", txRw, 0);
        if (accIdx < FLEN) begin
          chk(txAddr == 8'(accIdx), accIdx == 0 ? "R3 tag address" :
              accIdx <= 2 * NCH ? "R4 channel address" : "R5 fill address",
              txAddr, accIdx);
          chk(txData == expByte(accIdx), accIdx == 0 ? "R3 tag byte" :
              accIdx <= 2 * NCH ? "R4 channel byte" : "R5 fill byte",
              txData, expByte(accIdx));
          if (accIdx >= 1 && accIdx <= 2 * NCH)
            chk(int'(chSel) == (accIdx - 1) / 2, "R4 channel select", chSel, (accIdx - 1) / 2);
        end else if (accIdx == FLEN) begin
          chk(txAddr == 8'hFF, "R8 send address", txAddr, 8'hFF);
          chk(txData == 8'(FLEN), "R8 send length", txData, FLEN);
        end else begin
          chk(0, "R8 extra access after send", accIdx, FLEN);
        end
        accIdx++;
        goAddr = txAddr;
        cnt = 1 + int'($urandom % 4);
        if (($urandom % 3) == 0) doneNow = 1; // spurious done in the go cycle, R6
      end
      if (stateWr) begin
        chk(accIdx == FLEN + 1, "R9 finish after send", accIdx, FLEN + 1);
        chk(newState == 3'b010, "R9 next state code", newState, 3'b010);
        frames++;
        accIdx = 0;
        fill(frames);
      end else if (newState != 3'b000) begin
        chk(0, "R9 idle state code", newState, 0);
      end
      prevGo = txGo;
      txDone = doneNow;
    end
  end

endmodule

// File: tb/dac_frame_seq_bench.sv
module dac_frame_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] stateCode = 3'b000;

  int chkA, failA, frA, accA;
  int chkB, failB, frB, accB;
  int chkC, failC, frC, accC;
  int benchChecks = 0, benchFails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dac_frame_seq_agent #(.NCH(32)) u_agent32 (.clk(clk), .rstN(rstN), .stateCode(stateCode),
    .checks(chkA), .fails(failA), .frames(frA), .accIdx(accA));
  dac_frame_seq_agent #(.NCH(24)) u_agent24 (.clk(clk), .rstN(rstN), .stateCode(stateCode),
    .checks(chkB), .fails(failB), .frames(frB), .accIdx(accB));
  dac_frame_seq_agent #(.NCH(16)) u_agent16 (.clk(clk), .rstN(rstN), .stateCode(stateCode),
    .checks(chkC), .fails(failC), .frames(frC), .accIdx(accC));

  task automatic bchk(input bit ok, input string req, input int act, input int exp);
    benchChecks++;
    if (!ok) begin
      benchFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d",
             benchChecks + chkA + chkB + chkC, benchFails + failA + failB + failC);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      benchFails++;
      benchChecks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      summary();
    end
  end

  initial begin
    int base;
    void'($urandom(32'd90210));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: a non-trigger code never starts a frame
    stateCode = 3'b011;
    repeat (25) @(negedge clk);
    bchk(frA == 0 && accA == 0 && accC == 0, "R2 no start on other code", accA + accC, 0);

    for (int f = 0; f < 6; f++) begin
      base = frA;
      stateCode = 3'b111;
      if (f == 2) begin
        // R2: edge while busy must be ignored
        repeat (20) @(negedge clk);
        stateCode = 3'b001;
        @(negedge clk);
        stateCode = 3'b111;
      end
      wait (frA == base + 1 && frB == base + 1 && frC == base + 1);
      repeat (30) @(negedge clk);
      bchk(frA == base + 1 && frB == base + 1 && frC == base + 1,
           "R2 one frame per edge", frA, base + 1);
      bchk(accA == 0 && accB == 0 && accC == 0, "R2 no restart while held",
           accA + accB + accC, 0);
      stateCode = 3'($urandom % 7); // any code except the trigger
      repeat (3 + ($urandom % 5)) @(negedge clk);
    end

    bchk(frA == 6 && frB == 6 && frC == 6, "R9 frame count", frA, 6);
    finished = 1;
    summary();
  end

endmodule